// File: doc/BRIEF.md
# Timer Clock Source Selector

This block produces the count-enable pulses for a pair of 16-bit timer counters. Everything runs in one system clock domain. A single 5-bit prescaler is shared by both counters. Each counter has its own selector, so the two counters may draw from different sources at the same time.

Each selector can choose one of five sources:

- no clock;
- the prescaled system clock;
- single edges on a shared external pin, with the edge polarity selectable;
- prescaler ticks passed only while that pin is at a chosen level (pulse accumulation);
- rising edges of a slow asynchronous clock of about 32 kHz, after synchronization.

The external pin and the slow clock each cross into the system domain through a two-flop synchronizer. A third flop holds the previous synchronized sample, and edge detection compares the two.

A capture function elsewhere in the chip may claim the shared pin as its input. While the `cap_claim` input is high, both pin-based sources are blocked. Configuration is written through a small address/data write port. The prescaler value can be read back at any time. The counters, the capture logic and the bus logic are outside this block.

Top module: `tmr_clk_sel`

## Requirements
- R1: While reset is held, and right after it is released, `pre_value` reads 0 and `cnt_en` is all zero. Reset also clears the internal prescaler counter, so a counter selecting the prescaled source sees a pulse in the first cycle after reset.
- R2: Address 0 of the write port loads `cfg_wdata[4:0]` into the prescaler register, and `pre_value` shows the new value from the next cycle on. With register value N and no writes, prescaler ticks come exactly once every N+1 cycles. Source code 001 passes every tick to `cnt_en`.
- R3: A prescaler write does not cut short the division period in progress. The new value is loaded only when the internal down counter next reaches zero.
- R4: Address 1+i configures counter i. Bits [2:0] are the source code. Bit 3 is the edge polarity (0 = rising, 1 = falling). Bit 4 is the level polarity (1 = count while the pin is high, 0 = while it is low). With code 010, each pin edge of the selected polarity gives exactly one single-cycle pulse. The pulse appears three clock edges after the pin is sampled.
- R5: With code 011, a prescaler tick reaches `cnt_en` only while the synchronized pin is at the selected level.
- R6: While `cap_claim` is high, codes 010 and 011 produce no pulses.
- R7: With code 100, each rising edge of `slow_clk` gives exactly one single-cycle pulse, with the same latency as R4. `slow_clk` must run at no more than a quarter of the system clock.
- R8: Codes 000, 101, 110 and 111 never produce a pulse.
- R9: The two selectors are independent. Each counter's pulses depend only on its own configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the configuration port |
| cfg_addr | input | 2 | 0 = prescaler, 1 = counter 0 selector, 2 = counter 1 selector |
| cfg_wdata | input | 5 | Write data |
| ext_pin | input | 1 | Shared external event / gate pin (asynchronous) |
| slow_clk | input | 1 | Slow asynchronous clock |
| cap_claim | input | 1 | High while the capture logic owns the external pin |
| pre_value | output | 5 | Current prescaler register value |
| cnt_en | output | 2 | One count-enable bit per counter |

## Verification
The prescaled path is run with a ratio of 1, a mid ratio and the maximum ratio of 32. One rewrite lands in the middle of a period, which separates a reload-time update from an immediate one. The pin is driven with an irregular pattern while one counter counts rising edges and the other counts falling edges, which exposes a swapped or doubled edge detector. It is driven again under high and low gating with a non-unit ratio, which shows whether the level polarity and the tick are combined correctly. The capture claim is raised during both pin modes. The slow clock is run at two rates alongside a prescaled counter, and the unused codes are tried with every source active.

// File: rtl/tmr_clk_sel.sv
module tmr_clk_sel #(
  parameter int PW   = 5,
  parameter int NCNT = 2,
  localparam int AW  = $clog2(NCNT + 1),
  localparam int DW  = (PW > 5) ? PW : 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [DW-1:0]   cfg_wdata,
  input  logic            ext_pin,
  input  logic            slow_clk,
  input  logic            cap_claim,
  output logic [PW-1:0]   pre_value,
  output logic [NCNT-1:0] cnt_en
);
  localparam logic [2:0] SRC_PRE  = 3'd1;
  localparam logic [2:0] SRC_EDGE = 3'd2;
  localparam logic [2:0] SRC_ACC  = 3'd3;
  localparam logic [2:0] SRC_SLOW = 3'd4;

  logic [PW-1:0] pre_reg, pre_cnt;
  logic [2:0]    ext_s, slw_s;
  logic          tick, rise_x, fall_x, slow_rise;

  logic [NCNT-1:0][2:0] sel_q;
  logic [NCNT-1:0]      epol_q, lpol_q;

  assign tick      = (pre_cnt == '0);
  assign rise_x    = ext_s[1] & ~ext_s[2];
  assign fall_x    = ~ext_s[1] & ext_s[2];
  assign slow_rise = slw_s[1] & ~slw_s[2];
  assign pre_value = pre_reg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_reg <= '0;
      pre_cnt <= '0;
      ext_s   <= '0;
      slw_s   <= '0;
    end else begin
      ext_s   <= {ext_s[1:0], ext_pin};
      slw_s   <= {slw_s[1:0], slow_clk};
      pre_cnt <= tick ? pre_reg : pre_cnt - 1'b1;
      if (cfg_wr && cfg_addr == '0)
        pre_reg <= cfg_wdata[PW-1:0];
    end
  end

  for (genvar i = 0; i < NCNT; i++) begin : g_sel
    logic edge_hit, lvl_hit;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q[i]  <= '0;
        epol_q[i] <= 1'b0;
        lpol_q[i] <= 1'b0;
      end else if (cfg_wr && cfg_addr == AW'(i + 1)) begin
        sel_q[i]  <= cfg_wdata[2:0];
        epol_q[i] <= cfg_wdata[3];
        lpol_q[i] <= cfg_wdata[4];
      end
    end

    assign edge_hit = epol_q[i] ? fall_x : rise_x;
    assign lvl_hit  = lpol_q[i] ? ext_s[1] : ~ext_s[1];

    always_comb begin
      case (sel_q[i])
        SRC_PRE:  cnt_en[i] = tick;
        SRC_EDGE: cnt_en[i] = edge_hit & ~cap_claim;
        SRC_ACC:  cnt_en[i] = tick & lvl_hit & ~cap_claim;
        SRC_SLOW: cnt_en[i] = slow_rise;
        default:  cnt_en[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/tmr_clk_sel_chk.sv
module tmr_clk_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_wr,
  input logic [1:0] cfg_addr,
  input logic [4:0] cfg_wdata,
  input logic       cap_claim,
  input logic [4:0] pre_value,
  input logic [1:0] cnt_en,
  input logic [2:0] sel0
);
  p_pre_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == 2'd0) |=> (pre_value == $past(cfg_wdata)));

  p_pre_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel0 == 3'd1 || sel0 == 3'd3) && cnt_en[0] && pre_value != 5'd0 && !cfg_wr)
      |=> !cnt_en[0]);

  p_edge_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel0 == 3'd2 && cnt_en[0] && !cfg_wr) |=> !cnt_en[0]);

  p_cap_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_claim && (sel0 == 3'd2 || sel0 == 3'd3)) |-> !cnt_en[0]);

  p_slow_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel0 == 3'd4 && cnt_en[0] && !cfg_wr) |=> !cnt_en[0]);

  p_unused_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel0 == 3'd0 || sel0 > 3'd4) |-> !cnt_en[0]);
endmodule

bind tmr_clk_sel tmr_clk_sel_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_wr    (cfg_wr),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata),
  .cap_claim (cap_claim),
  .pre_value (pre_value),
  .cnt_en    (cnt_en),
  .sel0      (sel_q[0])
);

// File: tb/tmr_clk_sel_tb.sv
module tmr_clk_sel_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [4:0] cfg_wdata = '0;
  logic       ext_pin = 1'b0;
  logic       slow_clk = 1'b0;
  logic       cap_claim = 1'b0;
  logic [4:0] pre_value;
  logic [1:0] cnt_en;

  int total = 0;
  int bad = 0;
  bit started = 0;

  always #10 clk = ~clk;

  tmr_clk_sel u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ext_pin(ext_pin), .slow_clk(slow_clk),
    .cap_claim(cap_claim), .pre_value(pre_value), .cnt_en(cnt_en)
  );

  // behavioural reference state
  int m_preg, m_pcnt;
  int m_sel [2];
  bit m_epol [2];
  bit m_lpol [2];
  bit pin_q [$];
  bit slw_q [$];

  task automatic clear_model();
    m_preg = 0; m_pcnt = 0;
    for (int i = 0; i < 2; i++) begin
      m_sel[i] = 0; m_epol[i] = 0; m_lpol[i] = 0;
    end
    pin_q = '{0, 0, 0};
    slw_q = '{0, 0, 0};
  endtask

  initial clear_model();

  always @(posedge clk) begin
    if (!rst_n) clear_model();
    else begin
      pin_q.push_front(ext_pin); void'(pin_q.pop_back());
      slw_q.push_front(slow_clk); void'(slw_q.pop_back());
      if (m_pcnt == 0) m_pcnt = m_preg; else m_pcnt = m_pcnt - 1;
      if (cfg_wr) begin
        if (cfg_addr == 2'd0) m_preg = int'(cfg_wdata);
        else if (cfg_addr <= 2'd2) begin
          m_sel[cfg_addr-1]  = int'(cfg_wdata[2:0]);
          m_epol[cfg_addr-1] = cfg_wdata[3];
          m_lpol[cfg_addr-1] = cfg_wdata[4];
        end
      end
    end
    started = 1;
  end

  function automatic bit exp_en(int i);
    bit tk, p_now, p_old, s_now, s_old, ed, lv;
    tk = (m_pcnt == 0);
    p_now = pin_q[1]; p_old = pin_q[2];
    s_now = slw_q[1]; s_old = slw_q[2];
    ed = m_epol[i] ? (!p_now && p_old) : (p_now && !p_old);
    lv = m_lpol[i] ? p_now : !p_now;
    case (m_sel[i])
      1: return tk;
      2: return ed && !cap_claim;
      3: return tk && lv && !cap_claim;
      4: return s_now && !s_old;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int i);
    if (!rst_n) return "R1";
    case (m_sel[i])
      1: return "R2,R3";
      2: return cap_claim ? "R6" : "R4";
      3: return cap_claim ? "R6" : "R5";
      4: return "R7";
      default: return "R8";
    endcase
  endfunction

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      for (int i = 0; i < 2; i++) begin
        total++;
        if (cnt_en[i] !== exp_en(i)) begin
          bad++;
          $display("FAIL %s cnt_en[%0d] t=%0t actual=%0b expected=%0b",
                   tag_of(i), i, $time, cnt_en[i], exp_en(i));
        end
      end
      total++;
      if (int'(pre_value) != m_preg) begin
        bad++;
        $display("FAIL %s pre_value t=%0t actual=%0d expected=%0d",
                 rst_n ? "R2" : "R1", $time, pre_value, m_preg);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [4:0] d);
    @(negedge clk); #1;
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pin_noise(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1;
      if (($urandom % 3) == 0) ext_pin = ~ext_pin;
    end
  endtask

  task automatic slow_run(input int half, input int periods);
    for (int k = 0; k < 2 * periods; k++) begin
      @(negedge clk); #1;
      slow_clk = ~slow_clk;
      repeat (half - 1) @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset state observed on every cycle while reset is held
    idle(4);
    #1 rst_n = 1'b1;
    @(negedge clk);
    total++;
    if (pre_value !== 5'd0 || cnt_en !== 2'b00) begin
      bad++;
      $display("FAIL R1 after reset actual=%0d/%b expected=0/00", pre_value, cnt_en);
    end
    // R2: ratios 1, 5, 32; R3: rewrite mid-period
    wr(2'd1, 5'b00001);
    wr(2'd2, 5'b00001);
    idle(10);
    wr(2'd0, 5'd4);
    idle(12);
    wr(2'd0, 5'd31);
    idle(10);
    wr(2'd0, 5'd2);   // lands mid-period of the 32 divide
    idle(60);
    // R4: rising on counter 0, falling on counter 1
    wr(2'd1, 5'b00010);
    wr(2'd2, 5'b01010);
    pin_noise(80);
    // R5: gating high on counter 0, low on counter 1
    wr(2'd1, 5'b10011);
    wr(2'd2, 5'b00011);
    pin_noise(80);
    // R6: capture claim blocks both pin modes
    #1 cap_claim = 1'b1;
    pin_noise(30);
    wr(2'd1, 5'b00010);
    pin_noise(30);
    #1 cap_claim = 1'b0;
    pin_noise(20);
    // R7 with R9: slow clock on counter 0, prescaled on counter 1
    wr(2'd1, 5'b00100);
    wr(2'd2, 5'b00001);
    slow_run(2, 10);
    slow_run(5, 6);
    // R8: unused codes with every source active
    wr(2'd0, 5'd0);
    for (int c = 5; c < 8; c++) begin
      wr(2'd1, 5'(c));
      wr(2'd2, 5'(c) | 5'b11000);
      fork
        pin_noise(24);
        slow_run(3, 4);
      join
    end
    wr(2'd1, 5'b00000);
    pin_noise(10);
    idle(3);
    finish_run();
  end
endmodule